// File: doc/BRIEF.md
# Hardware/Software Selectable Clock Gate Controller

This block owns the on/off decision for one clock branch. The decision comes from one of two sources. The first is a hardware request line that asks for the clock whenever downstream logic is busy. The second is an enable bit that software writes into a 32-bit gate register. A select bit in the same register picks the source. The chosen enable drives a latch-based clock gate. The latch is open only while the input clock is low, so the gated clock never carries a shortened pulse.

Software cannot see the gate switch at once. It polls a read-only status bit, and that bit changes only after the effective enable has passed a two-stage synchronizer and a settle counter. A small state machine tracks the settle. Its states are ST_OFF (settled off), ST_RISE (turning on, counting settle cycles), ST_ON (settled on) and ST_FALL (turning off, counting settle cycles). The transitions are OFF_TO_RISE when the synchronized enable goes high, RISE_TO_ON when the count completes, RISE_ABORT back to ST_OFF when the enable drops early, ON_TO_FALL when the enable drops, FALL_TO_OFF when the count completes, and FALL_ABORT back to ST_ON when the enable returns early.

A build parameter picks one of four variants. In the selectable variant, software may own the gate. In the hold-on variant, the gate is forced on whenever software owns it. In the hardware-only variant, the gate follows the request line and has no control bits. In the gateless variant, the clock is always on.

Top module: `clkgate_ctl`

## Requirements
- R1: The status field (bit 8 of the gate register) reads 0 during reset. It reads 1 only once the gate has settled on, and it reads 0 once the gate has settled off.
- R2: In the selectable variant with the select field (bit 1) at 1, writing 1 to the enable field (bit 0) turns the gated clock on, and writing 0 turns it off.
- R3: With the select field at 0, the gated clock follows hw_req and ignores the enable field.
- R4: A register write taken at clock edge N shows on clk_out from the high phase of edge N+1. A hw_req level that is stable before edge N shows on clk_out in the high phase of edge N.
- R5: After a write at edge N, the status field takes the new state at edge N+5. After a hw_req change that is first sampled at edge N, the status field takes the new state at edge N+4.
- R6: An enable pulse shorter than the settle window never reaches the status field.
- R7: In the hold-on variant with the select field at 1, the clock stays on whatever the enable field holds. The enable field is still stored and read back.
- R8: In the hardware-only variant, the enable and select fields read 0 and writes do not change them. The gate follows hw_req.
- R9: In the gateless variant, clk_out always runs and the status field settles to 1.
- R10: Reset sets select and enable to 1. The gate register sits at address 0. Other addresses read 0, and writes to them change nothing.
- R11: The gate enable seen by clk_out never changes while the input clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Ungated source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| hw_req | input | 1 | Hardware clock request, 1 = clock needed |
| clk_out | output | 1 | Gated clock |

## Verification
The critical coincidence is a write that hands ownership back to hardware in the same cycle that hw_req rises. The bench provokes this by starting with software owning the gate and the clock on. It then drives hw_req high on the same low phase as a write that clears both select and enable. It judges the result by requiring clk_out to be high at every following rising edge, with the status field holding 1 throughout. A second coincidence is a hw_req pulse that ends inside the settle window. Here the bench requires exactly one gated clock pulse, with no status change at all.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Variant chosen at build time
    typedef enum logic [1:0] {
        GK_NONE     = 2'd0,  // no gate, clock always runs
        GK_HW_ONLY  = 2'd1,  // follows hardware request only
        GK_HW_SW    = 2'd2,  // selectable hardware or software ownership
        GK_HW_OR_ON = 2'd3   // hardware, or forced on when software owns it
    } gate_kind_e;

    // Settle tracker states
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RISE = 2'd1,
        ST_ON   = 2'd2,
        ST_FALL = 2'd3
    } settle_st_e;

endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs #(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] GATE_ADDR = '0,
    parameter logic [DATA_W-1:0] WR_MASK   = '0,
    parameter logic [DATA_W-1:0] RST_VAL   = '0,
    parameter int                STAT_BIT  = 8
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] ctrl_o
);

    localparam logic [DATA_W-1:0] RST_MASKED = RST_VAL & WR_MASK;

    logic              hit;
    logic [DATA_W-1:0] ctrl_q;

    assign hit = (addr_i == GATE_ADDR);

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= RST_MASKED;
        end else if (wr_i && hit) begin
            ctrl_q <= wdata_i & WR_MASK;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o           = ctrl_q & WR_MASK;
            rdata_o[STAT_BIT] = status_i;
        end
    end

    assign ctrl_o = ctrl_q;

    // R10
    other_addr_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (wr_i && !hit) |=> $stable(ctrl_q));

endmodule

// File: rtl/clkgate_src.sv
module clkgate_src
    import clkgate_pkg::*;
#(
    parameter gate_kind_e KIND = GK_HW_SW
) (
    input  logic sel_sw_i,
    input  logic sw_en_i,
    input  logic hw_req_i,
    output logic eff_en_o
);

    always_comb begin
        unique case (KIND)
            GK_NONE:     eff_en_o = 1'b1;
            GK_HW_ONLY:  eff_en_o = hw_req_i;
            GK_HW_SW:    eff_en_o = sel_sw_i ? sw_en_i : hw_req_i;
            GK_HW_OR_ON: eff_en_o = sel_sw_i | hw_req_i;
            default:     eff_en_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/clkgate_status.sv
module clkgate_status
    import clkgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE      = 2
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en_i,
    output logic status_o
);

    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

    logic sync_q [SYNC_STAGES];
    logic en_sync;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk_in or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[g] <= 1'b0;
            end else if (g == 0) begin
                sync_q[g] <= en_i;
            end else begin
                sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign en_sync = sync_q[SYNC_STAGES-1];

    settle_st_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        status_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (en_sync) begin
                    state_d = ST_RISE;
                    cnt_d   = '0;
                end
            end
            ST_RISE: begin
                if (!en_sync) begin
                    state_d = ST_OFF;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_ON;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ON: begin
                status_o = 1'b1;
                if (!en_sync) begin
                    state_d = ST_FALL;
                    cnt_d   = '0;
                end
            end
            ST_FALL: begin
                status_o = 1'b1;
                if (en_sync) begin
                    state_d = ST_ON;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_OFF;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // R1 R5
    status_rise_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(status_o) |-> ($past(en_sync) && $past(en_sync, 2)));

    // R1 R5
    status_fall_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(status_o) |-> (!$past(en_sync) && !$past(en_sync, 2)));

    // R6
    status_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!status_o && !en_sync) |=> !status_o);

endmodule

// File: rtl/clkgate_icg.sv
module clkgate_icg (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en_i,
    output logic clk_o
);

    logic en_lat;

    always_latch begin
        if (!clk_in) begin
            en_lat = en_i;
        end
    end

    assign clk_o = clk_in & en_lat;

    logic en_at_rise;
    always_ff @(posedge clk_in) begin
        en_at_rise <= en_lat;
    end

    // R11
    icg_hold_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
        en_lat == en_at_rise);

endmodule

// File: rtl/clkgate_ctl.sv
module clkgate_ctl
    import clkgate_pkg::*;
#(
    parameter gate_kind_e        KIND        = GK_HW_SW,
    parameter int                DATA_W      = 32,
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] GATE_ADDR   = '0,
    parameter int                EN_BIT      = 0,
    parameter int                SEL_BIT     = 1,
    parameter int                STAT_BIT    = 8,
    parameter bit                RST_SEL     = 1'b1,
    parameter bit                RST_EN      = 1'b1,
    parameter int                SYNC_STAGES = 2,
    parameter int                SETTLE      = 2
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hw_req,
    output logic              clk_out
);

    localparam bit WRITABLE = (KIND == GK_HW_SW) || (KIND == GK_HW_OR_ON);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        WRITABLE ? ((DATA_W'(1) << EN_BIT) | (DATA_W'(1) << SEL_BIT)) : '0;
    localparam logic [DATA_W-1:0] CTRL_RST =
        (DATA_W'(RST_EN) << EN_BIT) | (DATA_W'(RST_SEL) << SEL_BIT);

    logic [DATA_W-1:0] ctrl;
    logic              sel_sw;
    logic              sw_en;
    logic              eff_en;
    logic              status;

    clkgate_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .GATE_ADDR(GATE_ADDR),
        .WR_MASK  (CTRL_MASK),
        .RST_VAL  (CTRL_RST),
        .STAT_BIT (STAT_BIT)
    ) regs_i (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .status_i(status),
        .rdata_o (reg_rdata),
        .ctrl_o  (ctrl)
    );

    assign sel_sw = ctrl[SEL_BIT];
    assign sw_en  = ctrl[EN_BIT];

    clkgate_src #(
        .KIND(KIND)
    ) src_i (
        .sel_sw_i(sel_sw),
        .sw_en_i (sw_en),
        .hw_req_i(hw_req),
        .eff_en_o(eff_en)
    );

    clkgate_status #(
        .SYNC_STAGES(SYNC_STAGES),
        .SETTLE     (SETTLE)
    ) stat_i (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .en_i    (eff_en),
        .status_o(status)
    );

    clkgate_icg icg_i (
        .clk_in(clk_in),
        .rst_n (rst_n),
        .en_i  (eff_en),
        .clk_o (clk_out)
    );

    // R2
    sw_on_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (WRITABLE && reg_wr && reg_addr == GATE_ADDR &&
         reg_wdata[SEL_BIT] && reg_wdata[EN_BIT]) |=> eff_en);

    // R3
    hw_follow_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (KIND != GK_NONE && !sel_sw) |-> (eff_en == hw_req));

    // R7
    hold_on_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (KIND == GK_HW_OR_ON && sel_sw) |-> eff_en);

endmodule

// File: tb/clkgate_ctl_tb_top.sv
module clkgate_ctl_tb_top;
    import clkgate_pkg::*;

    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        hw_req = 1'b0;
    logic [31:0] rd_m, rd_nd, rd_ho, rd_ng;
    logic        ck_m, ck_nd, ck_ho, ck_ng;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk_in = ~clk_in;

    clkgate_ctl #(.KIND(GK_HW_SW)) dut_i (
        .clk_in(clk_in), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_m), .hw_req(hw_req), .clk_out(ck_m));
    clkgate_ctl #(.KIND(GK_HW_OR_ON)) dut_nd_i (
        .clk_in(clk_in), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_nd), .hw_req(hw_req), .clk_out(ck_nd));
    clkgate_ctl #(.KIND(GK_HW_ONLY)) dut_ho_i (
        .clk_in(clk_in), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_ho), .hw_req(hw_req), .clk_out(ck_ho));
    clkgate_ctl #(.KIND(GK_NONE)) dut_ng_i (
        .clk_in(clk_in), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_ng), .hw_req(hw_req), .clk_out(ck_ng));

    // {sel, en, hw, expected gate of the selectable variant}
    localparam logic [3:0] VEC [8] = '{
        4'b1101, 4'b1010, 4'b1000, 4'b0011,
        4'b0100, 4'b0000, 4'b1111, 4'b0111
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk_in);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk_in);
        @(negedge clk_in);
        reg_wr = 1'b0; reg_addr = '0;
    endtask

    task automatic settle();
        repeat (8) @(posedge clk_in);
        #2;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state: R1 R8 R10
        repeat (3) @(negedge clk_in);
        #1;
        chk(rd_m == 32'h3, "R10 reset sel/en", rd_m, 32'h3);
        chk(rd_m[8] == 1'b0, "R1 status in reset", {31'd0, rd_m[8]}, 0);
        chk(rd_ho == 32'h0, "R8 hw-only reset read", rd_ho, 0);
        @(negedge clk_in);
        rst_n = 1'b1;
        settle();
        chk(rd_m == 32'h103, "R1 status after reset settle", rd_m, 32'h103);

        // Table walk: R2 R3 R7 R8 R9
        for (int i = 0; i < 8; i++) begin
            logic s, e, h, x;
            {s, e, h, x} = VEC[i];
            @(negedge clk_in);
            hw_req = h;
            wr(4'd0, {30'd0, s, e});
            settle();
            chk(ck_m == x, "R2 R3 selectable gate", {31'd0, ck_m}, {31'd0, x});
            chk(rd_m == {23'd0, x, 6'd0, s, e}, "R1 selectable readback", rd_m,
                {23'd0, x, 6'd0, s, e});
            chk(ck_nd == (s | h), "R7 hold-on gate", {31'd0, ck_nd}, {31'd0, s | h});
            chk(rd_nd[1:0] == {s, e}, "R7 hold-on stores enable", {30'd0, rd_nd[1:0]},
                {30'd0, s, e});
            chk(ck_ho == h, "R8 hw-only gate", {31'd0, ck_ho}, {31'd0, h});
            chk(ck_ng == 1'b1, "R9 gateless clock", {31'd0, ck_ng}, 1);
        end

        // Write latency: R4 R5
        hw_req = 1'b0;
        wr(4'd0, 32'h2);
        settle();
        chk(ck_m == 1'b0, "R2 off before write", {31'd0, ck_m}, 0);
        wr(4'd0, 32'h3);
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk_in); #2;
            if (k == 1) chk(ck_m == 1'b1, "R4 write to clock", {31'd0, ck_m}, 1);
            if (k >= 4) chk(rd_m[8] == (k >= 5), "R5 write to status",
                            {31'd0, rd_m[8]}, {31'd0, k >= 5});
        end

        // hw_req latency: R4 R5
        wr(4'd0, 32'h0);
        settle();
        @(negedge clk_in);
        hw_req = 1'b1;
        @(posedge clk_in); #2;
        chk(ck_m == 1'b1, "R4 request to clock", {31'd0, ck_m}, 1);
        for (int k = 1; k <= 4; k++) begin
            @(posedge clk_in); #2;
            if (k >= 3) chk(rd_m[8] == (k >= 4), "R5 request to status",
                            {31'd0, rd_m[8]}, {31'd0, k >= 4});
        end

        // Short pulse: R6
        @(negedge clk_in);
        hw_req = 1'b0;
        settle();
        begin
            int hi_ck = 0;
            int hi_st = 0;
            @(negedge clk_in);
            hw_req = 1'b1;
            @(posedge clk_in); #2;
            hi_ck += ck_m; hi_st += rd_m[8];
            @(negedge clk_in);
            hw_req = 1'b0;
            for (int k = 0; k < 7; k++) begin
                @(posedge clk_in); #2;
                hi_ck += ck_m; hi_st += rd_m[8];
            end
            chk(hi_ck == 1, "R6 single gated pulse", hi_ck, 1);
            chk(hi_st == 0, "R6 status unchanged", hi_st, 0);
        end

        // Handover in the same cycle as hw_req rise: R3 R11
        wr(4'd0, 32'h3);
        settle();
        @(negedge clk_in);
        hw_req = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0;
        @(posedge clk_in); #2;
        chk(ck_m == 1'b1, "R11 handover edge", {31'd0, ck_m}, 1);
        @(negedge clk_in);
        reg_wr = 1'b0;
        begin
            int gaps = 0;
            for (int k = 0; k < 6; k++) begin
                @(posedge clk_in); #2;
                if (!ck_m || !rd_m[8]) gaps++;
            end
            chk(gaps == 0, "R3 handover continuous", gaps, 0);
        end
        chk(rd_m == 32'h100, "R3 handover readback", rd_m, 32'h100);

        // Other address: R10
        wr(4'd1, 32'h2);
        settle();
        chk(rd_m == 32'h100, "R10 other address write ignored", rd_m, 32'h100);
        chk(ck_m == 1'b1, "R10 gate unchanged", {31'd0, ck_m}, 1);
        @(negedge clk_in);
        reg_addr = 4'd1;
        #1;
        chk(rd_m == 32'h0, "R10 other address reads zero", rd_m, 0);
        reg_addr = 4'd0;

        // Hardware-only and gateless: R8 R9
        wr(4'd0, 32'h3);
        settle();
        chk(rd_ho == 32'h100, "R8 hw-only write ignored", rd_ho, 32'h100);
        @(negedge clk_in);
        hw_req = 1'b0;
        settle();
        chk(rd_ho == 32'h0, "R8 hw-only status off", rd_ho, 0);
        chk(ck_ho == 1'b0, "R8 hw-only gate off", {31'd0, ck_ho}, 0);
        chk(rd_ng == 32'h100, "R9 gateless status", rd_ng, 32'h100);
        chk(ck_ng == 1'b1, "R9 gateless clock", {31'd0, ck_ng}, 1);

        // Hold-on keeps enable field: R7
        wr(4'd0, 32'h2);
        settle();
        chk(rd_nd == 32'h102, "R7 hold-on forced on", rd_nd, 32'h102);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule